// File: doc/BRIEF.md
# Coherent Clock View and Oscillator-Fail Monitor

This block sits between a free-running time-of-day counter and the registers that a serial bus master reads. It keeps a visible copy of the seven clock bytes. While the bus interface reports that one of the clock bytes is being read, the copy is frozen, so a multi-byte read never sees a carry ripple through it. The underlying count keeps running during the freeze. When the read ends, or when the freeze has lasted its maximum window (250 ms of system clocks by default), the newest count is copied in a single cycle.

The block also owns the oscillator-fail flag, which is bit 6 of the control byte. The flag reads 1 after power-on and whenever the oscillator is found dead. The oscillator counts as dead when the stop bit is 1, or when no oscillator pulse has arrived for a programmable number of system clocks. Software can clear the flag by writing 0 to it. That write takes effect only once the oscillator has delivered four one-second ticks in a row without dying. Control-byte writes are not subject to the read freeze.

Top module: `rtc_view_guard`

## Requirements
- R1: After reset, `view_time` is all zeros and `osc_fail` is 1.
- R2: In a cycle where `rd_active` is 0, the next edge loads `view_time` with the `time_count` value present at that edge.
- R3: While `rd_active` stays 1, `view_time` stays unchanged for up to DEFER_CYC consecutive edges.
- R4: If `rd_active` stays 1 for more than DEFER_CYC edges, the edge after the last held edge loads the current `time_count`, and a new hold window of DEFER_CYC edges then starts.
- R5: On the first edge after `rd_active` returns to 0, `view_time` equals the latest `time_count`. Counts that arrived during the hold are not lost.
- R6: The oscillator is considered dead while `stop_bit` is 1, or once STOP_TIMEOUT edges in a row have passed with no `osc_pulse`.
- R7: A write with `of_wr`=1 and `of_wdata`=0 clears `osc_fail` on the next edge, provided at least RUN_SECS (4) `sec_tick` pulses have been counted while the oscillator was alive since it was last dead.
- R8: A clear write made before RUN_SECS live ticks have been counted is ignored, and `osc_fail` stays 1.
- R9: Any edge at which the oscillator is dead sets `osc_fail` to 1 and restarts the live-tick count from 0. `sec_tick` pulses that arrive while the oscillator is dead are not counted.
- R10: While `osc_pulse` arrives at least once every STOP_TIMEOUT edges and `stop_bit` is 0, a cleared `osc_fail` stays 0.
- R11: Writes to the fail flag act the same way whether or not `rd_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_count | input | TIME_W | Running clock bytes 0..6 from the time counter |
| rd_active | input | 1 | Bus interface is reading a clock byte (address 0..6) |
| osc_pulse | input | 1 | One-cycle pulse for each observed oscillator period |
| stop_bit | input | 1 | Oscillator stop control bit |
| sec_tick | input | 1 | One-cycle pulse at each second of oscillator time |
| of_wr | input | 1 | Write strobe for the fail flag |
| of_wdata | input | 1 | Value written to the fail flag |
| view_time | output | TIME_W | Bus-visible copy of the clock bytes |
| osc_fail | output | 1 | Oscillator-fail flag (control bit 6) |

## Verification
On every cycle, assertions check the following: the view follows the count whenever no read is active; the view stays frozen inside an unexpired window; the hold counter never passes its limit; a stop bit always forces the flag to 1; and the flag can fall only when the live-tick count has saturated and the oscillator is alive. Only the bench scenarios can show the rest. These are the exact edge at which a long read is forced to refresh and then re-freezes, that a refresh after a read returns the latest count and not a stale one, that early clear attempts are rejected at the flag output, and that losing pulses raises the flag only after the timeout and not before.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;

    // Live-tick count needed before a clear of the fail flag is honoured
    localparam int unsigned RUN_SECS_DEF = 4;

    // One software access to the fail flag
    typedef struct packed {
        logic wr;
        logic val;
    } of_cmd_t;

    // Oscillator health as seen by the flag logic
    typedef struct packed {
        logic dead;
        logic tick;
    } osc_stat_t;

endpackage

// File: rtl/view_latch.sv
module view_latch #(
    parameter int unsigned TIME_W    = 56,
    parameter int unsigned DEFER_CYC = 12_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_active,
    input  logic [TIME_W-1:0] time_count,
    output logic [TIME_W-1:0] view_time
);
    localparam int unsigned CW = $clog2(DEFER_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DEFER_CYC);

    typedef struct packed {
        logic [TIME_W-1:0] view;
        logic [CW-1:0]     cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rd_active && (s_q.cnt != LIMIT)) begin
            // hold the visible copy, spend one cycle of the window
            s_d.cnt = s_q.cnt + 1'b1;
        end else begin
            // no read, or window used up: take the newest count
            s_d.view = time_count;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign view_time = s_q.view;

    assert_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |=> view_time == $past(time_count));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && s_q.cnt != LIMIT) |=> $stable(view_time));

    assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LIMIT);

endmodule

// File: rtl/osc_watch.sv
module osc_watch #(
    parameter int unsigned STOP_TIMEOUT = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     osc_pulse,
    input  logic                     stop_bit,
    input  logic                     sec_tick,
    output rtc_guard_pkg::osc_stat_t stat
);
    localparam int unsigned IW = $clog2(STOP_TIMEOUT + 1);
    localparam logic [IW-1:0] IDLE_MAX = IW'(STOP_TIMEOUT);

    typedef struct packed {
        logic [IW-1:0] idle;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (osc_pulse) begin
            s_d.idle = '0;
        end else if (s_q.idle != IDLE_MAX) begin
            s_d.idle = s_q.idle + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat.dead = stop_bit || (s_q.idle == IDLE_MAX);
    assign stat.tick = sec_tick;

    assert_idle_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idle <= IDLE_MAX);

    assert_pulse_alive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_pulse && !stop_bit) |=> (s_q.idle == '0));

endmodule

// File: rtl/fail_flag.sv
module fail_flag #(
    parameter int unsigned RUN_SECS = rtc_guard_pkg::RUN_SECS_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  rtc_guard_pkg::osc_stat_t stat,
    input  rtc_guard_pkg::of_cmd_t   cmd,
    output logic                     osc_fail
);
    localparam int unsigned RW = $clog2(RUN_SECS + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(RUN_SECS);

    typedef struct packed {
        logic          flag;
        logic [RW-1:0] run;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (stat.dead) begin
            s_d.flag = 1'b1;
            s_d.run  = '0;
        end else begin
            if (stat.tick && (s_q.run != RUN_MAX)) begin
                s_d.run = s_q.run + 1'b1;
            end
            if (cmd.wr) begin
                if (cmd.val) begin
                    s_d.flag = 1'b1;
                end else if (s_q.run == RUN_MAX) begin
                    s_d.flag = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{flag: 1'b1, run: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign osc_fail = s_q.flag;

    assert_dead_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat.dead |=> (osc_fail && s_q.run == '0));

    assert_clear_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_fail) |-> ($past(s_q.run) == RUN_MAX && !$past(stat.dead)));

    assert_run_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run <= RUN_MAX);

endmodule

// File: rtl/rtc_view_guard.sv
module rtc_view_guard #(
    parameter int unsigned TIME_W       = 56,
    parameter int unsigned DEFER_CYC    = 12_500_000,
    parameter int unsigned STOP_TIMEOUT = 64,
    parameter int unsigned RUN_SECS     = rtc_guard_pkg::RUN_SECS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_count,
    input  logic              rd_active,
    input  logic              osc_pulse,
    input  logic              stop_bit,
    input  logic              sec_tick,
    input  logic              of_wr,
    input  logic              of_wdata,
    output logic [TIME_W-1:0] view_time,
    output logic              osc_fail
);
    rtc_guard_pkg::osc_stat_t stat;
    rtc_guard_pkg::of_cmd_t   cmd;

    assign cmd.wr  = of_wr;
    assign cmd.val = of_wdata;

    view_latch #(.TIME_W(TIME_W), .DEFER_CYC(DEFER_CYC)) u_view (
        .clk(clk), .rst_n(rst_n), .rd_active(rd_active),
        .time_count(time_count), .view_time(view_time)
    );

    osc_watch #(.STOP_TIMEOUT(STOP_TIMEOUT)) u_watch (
        .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse),
        .stop_bit(stop_bit), .sec_tick(sec_tick), .stat(stat)
    );

    fail_flag #(.RUN_SECS(RUN_SECS)) u_flag (
        .clk(clk), .rst_n(rst_n), .stat(stat), .cmd(cmd), .osc_fail(osc_fail)
    );

    assert_stop_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_bit |=> osc_fail);

endmodule

// File: tb/rtc_view_guard_test.sv
module rtc_view_guard_test;
    localparam int TW = 56;
    localparam int D  = 20;
    localparam int TO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TW-1:0] time_count = '0;
    logic rd_active = 0, osc_pulse = 0, stop_bit = 0, sec_tick = 0, of_wr = 0, of_wdata = 0;
    logic [TW-1:0] view_time;
    logic osc_fail;

    always #10 clk = ~clk;

    rtc_view_guard #(.TIME_W(TW), .DEFER_CYC(D), .STOP_TIMEOUT(TO)) uut (
        .clk(clk), .rst_n(rst_n), .time_count(time_count), .rd_active(rd_active),
        .osc_pulse(osc_pulse), .stop_bit(stop_bit), .sec_tick(sec_tick),
        .of_wr(of_wr), .of_wdata(of_wdata), .view_time(view_time), .osc_fail(osc_fail)
    );

    typedef struct {
        int          due;
        string       req;
        bit          cv;
        logic [TW-1:0] view;
        bit          cf;
        logic        of;
    } exp_t;

    exp_t q[$];
    int cyc = 0, n_chk = 0, n_fail = 0, tcnt = 0;
    bit osc_en = 1, done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares each expectation when its cycle has come
    always @(negedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            if (e.cv) begin
                n_chk++;
                if (view_time !== e.view) begin
                    n_fail++;
                    $display("FAIL %s view_time actual %0h expected %0h", e.req, view_time, e.view);
                end
            end
            if (e.cf) begin
                n_chk++;
                if (osc_fail !== e.of) begin
                    n_fail++;
                    $display("FAIL %s osc_fail actual %0b expected %0b", e.req, osc_fail, e.of);
                end
            end
        end
    end

    task automatic drive(bit rd, bit st, bit tk, bit wr, bit wv);
        @(negedge clk);
        tcnt++;
        time_count = TW'(tcnt) * 56'h1_0001;
        osc_pulse  = osc_en && (tcnt % 4 == 0);
        rd_active  = rd;
        stop_bit   = st;
        sec_tick   = tk;
        of_wr      = wr;
        of_wdata   = wv;
    endtask

    task automatic exp_view(string r, logic [TW-1:0] v);
        q.push_back('{due: cyc + 1, req: r, cv: 1, view: v, cf: 0, of: 0});
    endtask

    task automatic exp_of(string r, logic f);
        q.push_back('{due: cyc + 1, req: r, cv: 0, view: '0, cf: 1, of: f});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [TW-1:0] v0;
        // R1: reset state
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        exp_view("R1", '0);
        exp_of("R1", 1'b1);
        drive(0, 0, 0, 0, 0);
        rst_n = 1'b1;

        // R2: tracking with no read
        for (int i = 0; i < 5; i++) begin
            drive(0, 0, 0, 0, 0);
            exp_view("R2", time_count);
        end

        // R3 / R5: short read holds, then refresh to latest
        v0 = time_count;
        for (int i = 0; i < 10; i++) begin
            drive(1, 0, 0, 0, 0);
            exp_view("R3", v0);
        end
        drive(0, 0, 0, 0, 0);
        exp_view("R5", time_count);

        // R4: long read forced refresh and new window
        v0 = time_count;
        for (int k = 1; k <= 2 * (D + 1) + 3; k++) begin
            drive(1, 0, 0, 0, 0);
            if (k % (D + 1) == 0) begin
                exp_view("R4", time_count);
                v0 = time_count;
            end else begin
                exp_view("R4", v0);
            end
        end
        drive(0, 0, 0, 0, 0);
        exp_view("R5", time_count);

        // R8: clear too early is ignored
        drive(0, 0, 0, 1, 0);
        exp_of("R8", 1'b1);
        for (int i = 0; i < 3; i++) begin
            drive(0, 0, 1, 0, 0);
            drive(0, 0, 0, 0, 0);
        end
        drive(0, 0, 0, 1, 0);
        exp_of("R8", 1'b1);
        drive(0, 0, 1, 0, 0);
        // R7 + R11: honoured clear, issued during an active read
        drive(1, 0, 0, 1, 0);
        exp_of("R11", 1'b0);
        drive(0, 0, 0, 0, 0);
        exp_of("R7", 1'b0);

        // R10: running oscillator keeps the flag clear
        for (int i = 0; i < 20; i++) begin
            drive(0, 0, 0, 0, 0);
            exp_of("R10", 1'b0);
        end

        // R9 / R6: stop bit sets flag, ticks while dead do not count
        drive(0, 1, 0, 0, 0);
        exp_of("R6", 1'b1);
        for (int i = 0; i < 5; i++) drive(0, 1, 1, 0, 0);
        drive(0, 0, 0, 1, 0);
        exp_of("R9", 1'b1);
        for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 0);
        drive(0, 0, 0, 1, 0);
        exp_of("R9", 1'b1);
        drive(0, 0, 1, 0, 0);
        drive(0, 0, 0, 1, 0);
        exp_of("R7", 1'b0);

        // R6: missing pulses raise the flag only after the timeout
        osc_en = 0;
        for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 0);
        exp_of("R6", 1'b0);
        for (int i = 0; i < 17; i++) drive(0, 0, 0, 0, 0);
        exp_of("R6", 1'b1);
        for (int i = 0; i < 4; i++) drive(0, 0, 1, 0, 0);
        osc_en = 1;
        drive(0, 0, 0, 1, 0);
        exp_of("R9", 1'b1);

        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        finish_run();
    end
endmodule